// File: doc/BRIEF.md
# Time Slot Data Link Extractor

This block picks a low-rate data link out of a framed serial stream of 32 time slots with 8 bits each. Every received bit comes in with a bit clock enable and two position markers: one that flags the first bit of a frame and one that flags the first bit of each slot. The block counts slot and bit positions from these markers. It passes on only the bits that meet all three of its filters: the frame parity filter, the slot number filter and the per-bit mask.

Each selected bit leaves on a serial output with a one-cycle valid strobe, ready for a downstream HDLC receiver. The configuration inputs (mode, slot number and bit mask) are sampled only at the start of a frame, so a frame is never processed with mixed settings. Frame alignment, line decoding and HDLC deframing are handled elsewhere.

Top module: `ts_dl_extract`

## Requirements
- R1: An extracted bit appears on `dl_bit` together with `dl_valid` on the clock cycle after the `bit_en` cycle that carried it on `rx_bit`.
- R2: Only the slot whose index equals the sampled `cfg_slot` is extracted. Slot 0 starts at the bit flagged by `frame_sync`, and each `slot_sync` advances the index by one, up to 31.
- R3: Bit k of the selected slot (k = 0 is the first bit received) is extracted only when mask bit `cfg_mask[7-k]` is 1. A mask of all zeros extracts nothing.
- R4: `cfg_mode` encodings: 2'b00 off, 2'b01 every frame, 2'b10 odd frames only, 2'b11 even frames only.
- R5: The first frame after reset is frame 0 and counts as even. Frame parity alternates on every `frame_sync`.
- R6: `dl_valid` is high for exactly one cycle per extracted bit. It never rises for masked bits, for unselected slots or frames, or in a cycle after one with `bit_en` low.
- R7: The configuration is sampled on the `bit_en` cycle with `frame_sync` high. A change in the middle of a frame has no effect until the next frame starts.
- R8: In the off mode, and from reset until the first `frame_sync`, no bit is extracted.
- R9: During reset, `dl_valid` and `dl_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `rx_bit` and the markers for one bit time |
| rx_bit | input | 1 | Received serial data bit |
| frame_sync | input | 1 | High with the first bit of a frame |
| slot_sync | input | 1 | High with the first bit of each slot |
| cfg_mode | input | 2 | Frame filter mode (off, all, odd, even) |
| cfg_slot | input | 5 | Slot number to extract, 0 to 31 |
| cfg_mask | input | 8 | Per-bit enable; bit 7 is the first bit of the slot |
| dl_bit | output | 1 | Extracted data bit |
| dl_valid | output | 1 | One-cycle strobe for each extracted bit |

## Verification
The assertions check on every cycle that a strobe always follows a qualified bit and carries that bit's value. They also check that the held configuration changes only at a frame start, that frame parity flips exactly at each frame marker, and that an off mode or an empty mask produces no strobe. Whether the right slot, the right bit positions and the right frame parity are chosen can only be shown by the bench's frame scenarios. Those scenarios compare every output cycle against an independent position model, including mid-frame configuration changes and idle gaps between bits.

// File: rtl/ts_dl_extract.sv
module ts_dl_extract #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_en,
  input  logic                         rx_bit,
  input  logic                         frame_sync,
  input  logic                         slot_sync,
  input  logic [1:0]                   cfg_mode,
  input  logic [$clog2(SLOTS)-1:0]     cfg_slot,
  input  logic [SLOT_BITS-1:0]         cfg_mask,
  output logic                         dl_bit,
  output logic                         dl_valid
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(SLOT_BITS);
  localparam logic [BW-1:0] MSB_IDX = BW'(SLOT_BITS - 1);
  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_ALL  = 2'b01;
  localparam logic [1:0] MODE_ODD  = 2'b10;
  localparam logic [1:0] MODE_EVEN = 2'b11;

  logic [1:0]           act_mode;
  logic [SW-1:0]        act_slot;
  logic [SLOT_BITS-1:0] act_mask;
  logic [SW-1:0]        slot_q;
  logic [BW-1:0]        bit_q;
  logic                 odd_q;

  logic [SW-1:0]        cur_slot;
  logic [BW-1:0]        cur_bit;
  logic [BW-1:0]        mask_idx;
  logic                 cur_odd;
  logic [1:0]           eff_mode;
  logic [SW-1:0]        eff_slot;
  logic [SLOT_BITS-1:0] eff_mask;
  logic                 mode_ok;
  logic                 hit;

  assign cur_slot = frame_sync ? '0 : (slot_sync ? slot_q + SW'(1) : slot_q);
  assign cur_bit  = (frame_sync | slot_sync) ? '0 : bit_q + BW'(1);
  assign cur_odd  = frame_sync ? ~odd_q : odd_q;
  assign eff_mode = frame_sync ? cfg_mode : act_mode;
  assign eff_slot = frame_sync ? cfg_slot : act_slot;
  assign eff_mask = frame_sync ? cfg_mask : act_mask;
  assign mask_idx = MSB_IDX - cur_bit;

  always_comb begin
    case (eff_mode)
      MODE_ALL:  mode_ok = 1'b1;
      MODE_ODD:  mode_ok = cur_odd;
      MODE_EVEN: mode_ok = ~cur_odd;
      default:   mode_ok = 1'b0;
    endcase
  end

  assign hit = mode_ok & (cur_slot == eff_slot) & eff_mask[mask_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= MODE_OFF;
      act_slot <= '0;
      act_mask <= '0;
      slot_q   <= '0;
      bit_q    <= '0;
      odd_q    <= 1'b1;
      dl_valid <= 1'b0;
      dl_bit   <= 1'b0;
    end else begin
      dl_valid <= bit_en & hit;
      if (bit_en) begin
        slot_q <= cur_slot;
        bit_q  <= cur_bit;
        odd_q  <= cur_odd;
        if (hit) dl_bit <= rx_bit;
        if (frame_sync) begin
          act_mode <= cfg_mode;
          act_slot <= cfg_slot;
          act_mask <= cfg_mask;
        end
      end
    end
  end
endmodule

// File: rtl/ts_dl_extract_chk.sv
module ts_dl_extract_chk #(
  parameter int SW        = 5,
  parameter int SLOT_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_en,
  input logic                 rx_bit,
  input logic                 frame_sync,
  input logic                 dl_bit,
  input logic                 dl_valid,
  input logic [1:0]           act_mode,
  input logic [SW-1:0]        act_slot,
  input logic [SLOT_BITS-1:0] act_mask,
  input logic                 odd_q
);
  p_valid_needs_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dl_valid |-> $past(bit_en));

  p_data_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dl_valid |-> dl_bit == $past(rx_bit));

  p_cfg_frame_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && frame_sync) |=> $stable(act_mode) && $stable(act_slot) && $stable(act_mask));

  p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !frame_sync && act_mode == 2'b00) |=> !dl_valid);

  p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !frame_sync && act_mask == '0) |=> !dl_valid);

  p_parity_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_sync) |=> odd_q != $past(odd_q));

  p_parity_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && frame_sync) |=> $stable(odd_q));
endmodule

bind ts_dl_extract ts_dl_extract_chk #(.SW(SW), .SLOT_BITS(SLOT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
  .frame_sync(frame_sync), .dl_bit(dl_bit), .dl_valid(dl_valid),
  .act_mode(act_mode), .act_slot(act_slot), .act_mask(act_mask), .odd_q(odd_q)
);

// File: tb/ts_dl_extract_tb.sv
module ts_dl_extract_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, rx_bit = 1'b0, frame_sync = 1'b0, slot_sync = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [4:0] cfg_slot = '0;
  logic [7:0] cfg_mask = '0;
  logic       dl_bit, dl_valid;
  int total = 0, bad = 0, frame_cnt = 0;

  always #2 clk = ~clk;

  ts_dl_extract u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_sync(frame_sync), .slot_sync(slot_sync), .cfg_mode(cfg_mode),
    .cfg_slot(cfg_slot), .cfg_mask(cfg_mask), .dl_bit(dl_bit), .dl_valid(dl_valid)
  );

  // mode, slot, mask, frames, gap
  localparam logic [17:0] VEC [7] = '{
    {2'b01, 5'd5,  8'hFF, 2'd2, 1'b0},
    {2'b01, 5'd0,  8'h81, 2'd1, 1'b1},
    {2'b01, 5'd31, 8'h5A, 2'd1, 1'b0},
    {2'b10, 5'd3,  8'hFF, 2'd2, 1'b0},
    {2'b11, 5'd3,  8'hFF, 2'd2, 1'b1},
    {2'b00, 5'd3,  8'hFF, 2'd1, 1'b0},
    {2'b01, 5'd7,  8'h00, 2'd1, 1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic cycle(input logic be, input logic fs, input logic ss,
                       input logic rx, input logic expv, input string tag);
    bit_en = be; frame_sync = fs; slot_sync = ss; rx_bit = rx;
    @(negedge clk);
    total++;
    if (dl_valid !== expv || (expv && dl_bit !== rx)) begin
      bad++;
      $display("FAIL %s: valid=%0b bit=%0b expected valid=%0b bit=%0b",
               tag, dl_valid, dl_bit, expv, rx);
    end
  endtask

  task automatic run_frame(input logic [1:0] m, input logic [4:0] s, input logic [7:0] k,
                           input bit gap, input int chg_at, input logic [1:0] m2,
                           input logic [4:0] s2, input logic [7:0] k2, input string tag);
    bit odd = (frame_cnt % 2) == 1;
    bit mode_ok = (m == 2'b01) || (m == 2'b10 && odd) || (m == 2'b11 && !odd);
    cfg_mode = m; cfg_slot = s; cfg_mask = k;
    for (int sl = 0; sl < 32; sl++) begin
      if (sl == chg_at) begin cfg_mode = m2; cfg_slot = s2; cfg_mask = k2; end
      for (int b = 0; b < 8; b++) begin
        logic rx = logic'(((sl * 13 + b * 5 + frame_cnt * 3) >> 1) & 1);
        logic ex = mode_ok && (sl == s) && k[7 - b];
        cycle(1'b1, sl == 0 && b == 0, b == 0, rx, ex, tag);
        if (gap) cycle(1'b0, 1'b0, 1'b0, ~rx, 1'b0, "R6");
      end
    end
    frame_cnt++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (dl_valid !== 1'b0 || dl_bit !== 1'b0) begin
      bad++;
      $display("FAIL R9: valid=%0b bit=%0b expected valid=0 bit=0", dl_valid, dl_bit);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R8: enabled config but no frame start seen yet
    cfg_mode = 2'b01; cfg_slot = 5'd0; cfg_mask = 8'hFF;
    for (int i = 0; i < 24; i++) cycle(1'b1, 1'b0, (i % 8) == 0, 1'b1, 1'b0, "R8");

    for (int v = 0; v < 7; v++) begin
      for (int f = 0; f < int'(VEC[v][2:1]); f++)
        run_frame(VEC[v][17:16], VEC[v][15:11], VEC[v][10:3], VEC[v][0], 99,
                  2'b00, 5'd0, 8'h00, tag_of(v));
    end

    // R7: mid-frame switch to off does not stop the current frame
    run_frame(2'b01, 5'd20, 8'hFF, 1'b0, 10, 2'b00, 5'd20, 8'h00, "R7");
    // R7: mid-frame enable does not start extraction in the current frame
    run_frame(2'b00, 5'd4, 8'hFF, 1'b0, 2, 2'b01, 5'd4, 8'hFF, "R7");
    // R1: stream with gaps, selected slot fully enabled
    run_frame(2'b01, 5'd12, 8'hFF, 1'b1, 99, 2'b01, 5'd12, 8'hFF, "R1");

    bit_en = 1'b0; frame_sync = 1'b0; slot_sync = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule